// File: doc/BRIEF.md
# CAN Receive Message Buffer Match Engine

This block keeps a small bank of receive message buffers for a CAN controller and files each error-free received frame into one of them. An upstream receiver presents a finished frame as a record: identifier, length code and up to eight data bytes, with a one-cycle valid strobe. The block compares that identifier with every buffer that is ready to accept, picks the lowest-numbered hit, and copies in the identifier, length, payload and the free-running timer value. It then moves the buffer's state code forward and raises that buffer's interrupt flag.

A CPU prepares buffers through a word-addressed register port. It sets a buffer's identifier, acceptance mask and state code, and reads back everything the engine stored. Interrupt flags are cleared by writing ones. A mask register decides which flags drive the single combined interrupt line. A CPU write that changes a buffer's state code while a frame is being filed takes that buffer out of the running, so the frame goes to the next eligible hit, or nowhere.

The frame is sampled on the clock edge where `rx_valid` is high (edge A). It is filed on the following edge (edge B), where flags and state codes change. The combined interrupt follows one edge after that.

Top module: `canrx_mb_engine`

## Requirements
- R1: After synchronous reset, every buffer's state code reads INACTIVE (4'b0000), all interrupt flags are 0, the interrupt mask is 0 and `irq` is 0.
- R2: Only buffers whose state code is EMPTY (4'b0100), FULL (4'b0010) or OVERRUN (4'b0110) can receive a frame. An INACTIVE buffer is never written, even if its identifier matches and it has the lowest index.
- R3: A buffer matches when ((received ID XOR buffer ID) AND buffer mask) is zero. A mask bit of 0 makes that ID bit a don't-care. A frame that matches no eligible buffer changes no flag and no buffer.
- R4: When several eligible buffers match, only the lowest-index one receives the frame. The others keep their code and contents.
- R5: On storing, the buffer holds the received length, the eight data bytes, and the `timer` value sampled on the `rx_valid` edge. These read back through the control word, which has the code in bits [3:0], the length in [11:8] and the timestamp in [31:16], and through two data words, each holding four bytes with the lowest-numbered byte in bits [7:0].
- R6: Storing into an EMPTY buffer sets it to FULL. Storing into a FULL or OVERRUN buffer sets it to OVERRUN and overwrites its stored contents.
- R7: Storing into buffer k sets flag bit k on edge B. Writing a 1 to a flag bit clears it, and writing a 0 leaves it unchanged. If a set and a clear of the same bit happen in one cycle, the set wins.
- R8: `irq` is a register that is high one edge after any flag bit is set while its interrupt-mask bit is set. It is low when no enabled flag is set.
- R9: A CPU write to a buffer's control word that changes its code, made in the `rx_valid` cycle or in the following cycle, keeps the pending frame out of that buffer. The next-lowest eligible match receives the frame instead.
- R10: The stored identifier is always the received one, so ID bits that the mask ignored read back as the frame's bits rather than the CPU-written ones.
- R11: Register address = {global, buffer[3:0], word[2:0]}. Buffer words are: 0 control (the CPU writes only the code), 1 ID, 2 mask, 3 data bytes 0–3, 4 data bytes 4–7. Global words are: 0 flags (write 1 to clear), 1 interrupt mask. `reg_rdata` shows the addressed word one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | One-cycle strobe for an error-free received frame |
| rx_id | input | 29 | Received identifier |
| rx_len | input | 4 | Received length code |
| rx_data | input | 64 | Received payload, byte 0 in bits [7:0] |
| timer | input | 16 | Free-running timer value |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the address |
| irq_flags | output | 16 | Per-buffer interrupt flags |
| irq | output | 1 | Combined interrupt, gated by the interrupt mask |

## Verification
Frames are sent against buffer setups built to tell the selection rules apart. An exact-ID hit shows the basic store. A near-miss ID shows that the comparison is not loose. Two equal matching buffers with an INACTIVE one below them separate lowest-index priority from eligibility. A masked low nibble shows that don't-care bits match and that the stored ID comes from the frame. Repeated frames into one buffer walk the code through FULL and OVERRUN and show the overwrite. A code-changing CPU write is timed into the sample cycle and into the filing cycle to show that the frame falls through to the next buffer. The interrupt is watched across mask changes and flag clears to pin down its one-cycle lag.

// File: rtl/canrx_pkg.sv
package canrx_pkg;

  localparam logic [3:0] MB_INACTIVE = 4'b0000;
  localparam logic [3:0] MB_EMPTY    = 4'b0100;
  localparam logic [3:0] MB_FULL     = 4'b0010;
  localparam logic [3:0] MB_OVERRUN  = 4'b0110;

  localparam int LEN_W   = 4;
  localparam int BYTES   = 8;
  localparam int DATA_W  = 8 * BYTES;
  localparam int REG_W   = 32;

  // buffer word select
  localparam logic [2:0] W_CTRL = 3'd0;
  localparam logic [2:0] W_ID   = 3'd1;
  localparam logic [2:0] W_MASK = 3'd2;
  localparam logic [2:0] W_DLO  = 3'd3;
  localparam logic [2:0] W_DHI  = 3'd4;

  // global word select
  localparam logic [2:0] G_FLAGS = 3'd0;
  localparam logic [2:0] G_IMASK = 3'd1;

  function automatic logic code_eligible(input logic [3:0] c);
    return (c == MB_EMPTY) || (c == MB_FULL) || (c == MB_OVERRUN);
  endfunction

  function automatic logic [3:0] code_after_store(input logic [3:0] c);
    return (c == MB_EMPTY) ? MB_FULL : MB_OVERRUN;
  endfunction

endpackage

// File: rtl/canrx_match_vec.sv
module canrx_match_vec
  import canrx_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int ID_W   = 29
) (
  input  logic [ID_W-1:0]              rx_id,
  input  logic [NUM_MB-1:0][ID_W-1:0]  mb_id,
  input  logic [NUM_MB-1:0][ID_W-1:0]  mb_mask,
  input  logic [NUM_MB-1:0][3:0]       mb_code,
  output logic [NUM_MB-1:0]            hit
);

  for (genvar k = 0; k < NUM_MB; k++) begin : g_mb
    logic elig;
    logic id_eq;
    assign elig   = code_eligible(mb_code[k]);
    assign id_eq  = (((rx_id ^ mb_id[k]) & mb_mask[k]) == '0);
    assign hit[k] = elig & id_eq;
  end

endmodule

// File: rtl/canrx_lowest_pick.sv
module canrx_lowest_pick #(
  parameter int N  = 16,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  grant,
  output logic [IW-1:0] idx,
  output logic          any
);

  always_comb begin
    grant = '0;
    idx   = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req[k]) begin
        grant    = '0;
        grant[k] = 1'b1;
        idx      = IW'(k);
      end
    end
    any = |req;
  end

endmodule

// File: rtl/canrx_mb_engine.sv
module canrx_mb_engine
  import canrx_pkg::*;
#(
  parameter int NUM_MB = 16,
  parameter int ID_W   = 29,
  parameter int TS_W   = 16,
  localparam int MB_AW  = (NUM_MB > 1) ? $clog2(NUM_MB) : 1,
  localparam int ADDR_W = MB_AW + 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic [ID_W-1:0]   rx_id,
  input  logic [LEN_W-1:0]  rx_len,
  input  logic [DATA_W-1:0] rx_data,
  input  logic [TS_W-1:0]   timer,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic [NUM_MB-1:0] irq_flags,
  output logic              irq
);

  // ---------------- register decode ----------------
  logic             sel_glb;
  logic [MB_AW-1:0] sel_mb;
  logic [2:0]       sel_word;

  assign sel_glb  = reg_addr[ADDR_W-1];
  assign sel_mb   = reg_addr[MB_AW+2:3];
  assign sel_word = reg_addr[2:0];

  // ---------------- buffer state (flops, matched in parallel) ----------------
  logic [NUM_MB-1:0][3:0]      code_q;
  logic [NUM_MB-1:0][ID_W-1:0] id_q;
  logic [NUM_MB-1:0][ID_W-1:0] mask_q;
  logic [NUM_MB-1:0]           flags_q;
  logic [NUM_MB-1:0]           irq_mask_q;
  logic                        irq_q;

  // ---------------- payload storage (single write port, registered read) ----------------
  logic [DATA_W-1:0] data_mem [NUM_MB];
  logic [LEN_W-1:0]  len_mem  [NUM_MB];
  logic [TS_W-1:0]   ts_mem   [NUM_MB];

  // ---------------- code-change write detection ----------------
  logic              wr_ctrl;
  logic [NUM_MB-1:0] drop;

  assign wr_ctrl = reg_we & ~sel_glb & (sel_word == W_CTRL);

  always_comb begin
    drop = '0;
    if (wr_ctrl && (reg_wdata[3:0] != code_q[sel_mb]))
      drop[sel_mb] = 1'b1;
  end

  // ---------------- stage A: compare and sample the frame ----------------
  logic [NUM_MB-1:0] hit_raw;

  canrx_match_vec #(
    .NUM_MB (NUM_MB),
    .ID_W   (ID_W)
  ) u_match (
    .rx_id   (rx_id),
    .mb_id   (id_q),
    .mb_mask (mask_q),
    .mb_code (code_q),
    .hit     (hit_raw)
  );

  logic [NUM_MB-1:0] p_hit;
  logic [ID_W-1:0]   p_id;
  logic [LEN_W-1:0]  p_len;
  logic [DATA_W-1:0] p_data;
  logic [TS_W-1:0]   p_ts;

  always_ff @(posedge clk) begin
    if (rst) begin
      p_hit <= '0;
    end else begin
      p_hit <= rx_valid ? (hit_raw & ~drop) : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rx_valid) begin
      p_id   <= rx_id;
      p_len  <= rx_len;
      p_data <= rx_data;
      p_ts   <= timer;
    end
  end

  // ---------------- stage B: pick lowest survivor and commit ----------------
  logic [NUM_MB-1:0] cand;
  logic [NUM_MB-1:0] grant;
  logic [MB_AW-1:0]  gidx;
  logic              gany;

  assign cand = p_hit & ~drop;

  canrx_lowest_pick #(
    .N (NUM_MB)
  ) u_pick (
    .req   (cand),
    .grant (grant),
    .idx   (gidx),
    .any   (gany)
  );

  logic [NUM_MB-1:0] flag_clr;
  assign flag_clr = (reg_we && sel_glb && (sel_word == G_FLAGS)) ?
                    reg_wdata[NUM_MB-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q     <= '0;
      id_q       <= '0;
      mask_q     <= '0;
      flags_q    <= '0;
      irq_mask_q <= '0;
      irq_q      <= 1'b0;
    end else begin
      if (reg_we && !sel_glb) begin
        case (sel_word)
          W_CTRL:  code_q[sel_mb] <= reg_wdata[3:0];
          W_ID:    id_q[sel_mb]   <= reg_wdata[ID_W-1:0];
          W_MASK:  mask_q[sel_mb] <= reg_wdata[ID_W-1:0];
          default: ;
        endcase
      end
      if (reg_we && sel_glb && (sel_word == G_IMASK))
        irq_mask_q <= reg_wdata[NUM_MB-1:0];
      // commit overrides any CPU write to the chosen buffer
      if (gany) begin
        code_q[gidx] <= code_after_store(code_q[gidx]);
        id_q[gidx]   <= p_id;
      end
      flags_q <= (flags_q & ~flag_clr) | grant;
      irq_q   <= |(flags_q & irq_mask_q);
    end
  end

  always_ff @(posedge clk) begin
    if (gany) begin
      data_mem[gidx] <= p_data;
      len_mem[gidx]  <= p_len;
      ts_mem[gidx]   <= p_ts;
    end
  end

  // ---------------- readback ----------------
  logic [DATA_W-1:0] data_rd_q;
  logic [LEN_W-1:0]  len_rd_q;
  logic [TS_W-1:0]   ts_rd_q;

  always_ff @(posedge clk) begin
    data_rd_q <= data_mem[sel_mb];
    len_rd_q  <= len_mem[sel_mb];
    ts_rd_q   <= ts_mem[sel_mb];
  end

  logic              glb_rd_q;
  logic [2:0]        word_rd_q;
  logic [3:0]        code_rd_q;
  logic [ID_W-1:0]   id_rd_q;
  logic [ID_W-1:0]   mask_rd_q;
  logic [NUM_MB-1:0] flags_rd_q;
  logic [NUM_MB-1:0] imask_rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      glb_rd_q   <= 1'b0;
      word_rd_q  <= '0;
      code_rd_q  <= '0;
      id_rd_q    <= '0;
      mask_rd_q  <= '0;
      flags_rd_q <= '0;
      imask_rd_q <= '0;
    end else begin
      glb_rd_q   <= sel_glb;
      word_rd_q  <= sel_word;
      code_rd_q  <= code_q[sel_mb];
      id_rd_q    <= id_q[sel_mb];
      mask_rd_q  <= mask_q[sel_mb];
      flags_rd_q <= flags_q;
      imask_rd_q <= irq_mask_q;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (glb_rd_q) begin
      case (word_rd_q)
        G_FLAGS: reg_rdata[NUM_MB-1:0] = flags_rd_q;
        G_IMASK: reg_rdata[NUM_MB-1:0] = imask_rd_q;
        default: ;
      endcase
    end else begin
      case (word_rd_q)
        W_CTRL: begin
          reg_rdata[3:0]       = code_rd_q;
          reg_rdata[11:8]      = len_rd_q;
          reg_rdata[16 +: TS_W] = ts_rd_q;
        end
        W_ID:    reg_rdata[ID_W-1:0] = id_rd_q;
        W_MASK:  reg_rdata[ID_W-1:0] = mask_rd_q;
        W_DLO:   reg_rdata = data_rd_q[31:0];
        W_DHI:   reg_rdata = data_rd_q[63:32];
        default: ;
      endcase
    end
  end

  assign irq_flags = flags_q;
  assign irq       = irq_q;

endmodule

// File: rtl/canrx_mb_chk.sv
module canrx_mb_chk #(
  parameter int NUM_MB = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   irq,
  input logic [NUM_MB-1:0]      irq_flags,
  input logic [NUM_MB-1:0]      irq_mask,
  input logic [NUM_MB-1:0]      grant,
  input logic [NUM_MB-1:0][3:0] codes
);

  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant));

  // R7
  flag_rise_single_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(irq_flags & ~$past(irq_flags)));

  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(|(irq_flags & irq_mask)));

  for (genvar k = 0; k < NUM_MB; k++) begin : g_buf
    // R2
    grant_eligible_chk: assert property (@(posedge clk) disable iff (rst)
      grant[k] |-> (codes[k] == 4'b0100 || codes[k] == 4'b0010 || codes[k] == 4'b0110));

    // R6
    code_advance_chk: assert property (@(posedge clk) disable iff (rst)
      grant[k] |=> (codes[k] == 4'b0010 || codes[k] == 4'b0110));
  end

endmodule

bind canrx_mb_engine canrx_mb_chk #(
  .NUM_MB (NUM_MB)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irq       (irq),
  .irq_flags (irq_flags),
  .irq_mask  (irq_mask_q),
  .grant     (grant),
  .codes     (code_q)
);

// File: tb/canrx_mb_engine_tb.sv
module canrx_mb_engine_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NMB = 16;
  localparam int IDW = 29;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rx_valid = 1'b0;
  logic [28:0] rx_id = '0;
  logic [3:0]  rx_len = '0;
  logic [63:0] rx_data = '0;
  logic [15:0] timer = '0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [15:0] irq_flags;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  canrx_mb_engine #(.NUM_MB(NMB), .ID_W(IDW), .TS_W(16)) dut_i (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_id(rx_id), .rx_len(rx_len),
    .rx_data(rx_data), .timer(timer), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_flags(irq_flags), .irq(irq)
  );

  function automatic logic [7:0] mba(input int mb, input int word);
    return {1'b0, mb[3:0], word[2:0]};
  endfunction

  function automatic logic [7:0] gla(input int word);
    return {1'b1, 4'b0000, word[2:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst = 1'b1; rx_valid = 1'b0; reg_we = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic setup_mb(input int mb, input logic [28:0] id, input logic [28:0] msk,
                          input logic [3:0] code);
    wr(mba(mb, 1), {3'b0, id});
    wr(mba(mb, 2), {3'b0, msk});
    wr(mba(mb, 0), {28'b0, code});
  endtask

  task automatic send(input logic [28:0] id, input logic [3:0] len,
                      input logic [63:0] data, input logic [15:0] ts);
    rx_valid = 1'b1; rx_id = id; rx_len = len; rx_data = data; timer = ts;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    apply_reset();
    chk("R1 flags", {16'b0, irq_flags}, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);
    rd(mba(0, 0), v);  chk("R1 code mb0", v & 32'hF, 32'h0);
    rd(mba(15, 0), v); chk("R1 code mb15", v & 32'hF, 32'h0);
    rd(gla(1), v);     chk("R1 imask", v, 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    apply_reset();
    setup_mb(3, 29'h123, 29'h1FFFFFFF, 4'b0100);
    send(29'h123, 4'd8, 64'h8877665544332211, 16'h1234);
    chk("R7 flag set", {16'b0, irq_flags}, 32'h0000_0008);
    rd(mba(3, 0), v); chk("R5 R6 ctrl", v, 32'h1234_0802);
    rd(mba(3, 1), v); chk("R5 id", v, 32'h0000_0123);
    rd(mba(3, 3), v); chk("R5 data lo", v, 32'h4433_2211);
    rd(mba(3, 4), v); chk("R5 data hi", v, 32'h8877_6655);
    rd(gla(0), v);    chk("R11 flags word", v, 32'h0000_0008);
    wr(gla(0), 32'h0000_0001);
    chk("R7 write0 keeps", {16'b0, irq_flags}, 32'h0000_0008);
    wr(gla(0), 32'h0000_0008);
    chk("R7 w1c", {16'b0, irq_flags}, 32'h0);
    send(29'h124, 4'd2, 64'hFFFF, 16'h0001);
    chk("R3 no match flags", {16'b0, irq_flags}, 32'h0);
    rd(mba(3, 0), v); chk("R3 no match ctrl", v, 32'h1234_0802);
  endtask

  task automatic t_lowest();
    logic [31:0] v;
    apply_reset();
    setup_mb(2, 29'h0AB, 29'h1FFFFFFF, 4'b0000);
    setup_mb(5, 29'h0AB, 29'h1FFFFFFF, 4'b0100);
    setup_mb(9, 29'h0AB, 29'h1FFFFFFF, 4'b0100);
    send(29'h0AB, 4'd1, 64'h5A, 16'h0042);
    chk("R4 R2 lowest eligible", {16'b0, irq_flags}, 32'h0000_0020);
    rd(mba(9, 0), v); chk("R4 mb9 untouched", v & 32'hF, 32'h4);
    rd(mba(2, 0), v); chk("R2 inactive untouched", v & 32'hF, 32'h0);
    rd(mba(5, 0), v); chk("R4 mb5 ctrl", v, 32'h0042_0102);
  endtask

  task automatic t_overrun();
    logic [31:0] v;
    apply_reset();
    setup_mb(1, 29'h7, 29'h1FFFFFFF, 4'b0100);
    send(29'h7, 4'd8, 64'h1111_1111_1111_1111, 16'h0001);
    rd(mba(1, 0), v); chk("R6 first full", v, 32'h0001_0802);
    send(29'h7, 4'd8, 64'hAAAA_BBBB_CCCC_DDDD, 16'h0002);
    rd(mba(1, 0), v); chk("R6 overrun", v, 32'h0002_0806);
    rd(mba(1, 3), v); chk("R6 overwrite lo", v, 32'hCCCC_DDDD);
    rd(mba(1, 4), v); chk("R6 overwrite hi", v, 32'hAAAA_BBBB);
    send(29'h7, 4'd4, 64'h0, 16'h0003);
    rd(mba(1, 0), v); chk("R6 stays overrun", v, 32'h0003_0406);
  endtask

  task automatic t_mask();
    logic [31:0] v;
    apply_reset();
    setup_mb(7, 29'h500, 29'h1FFFFFF0, 4'b0100);
    send(29'h50A, 4'd3, 64'h00C0_FFEE, 16'h0077);
    chk("R3 masked hit", {16'b0, irq_flags}, 32'h0000_0080);
    rd(mba(7, 1), v); chk("R10 stored id", v, 32'h0000_050A);
    wr(gla(0), 32'h0000_0080);
    send(29'h51A, 4'd3, 64'h0, 16'h0078);
    chk("R3 masked miss", {16'b0, irq_flags}, 32'h0);
  endtask

  task automatic t_irq();
    apply_reset();
    setup_mb(0, 29'h10, 29'h1FFFFFFF, 4'b0100);
    send(29'h10, 4'd0, 64'h0, 16'h0);
    @(posedge clk); @(negedge clk);
    chk("R8 masked off", {31'b0, irq}, 32'h0);
    wr(gla(1), 32'h0000_0001);
    @(posedge clk); @(negedge clk);
    chk("R8 enabled", {31'b0, irq}, 32'h1);
    wr(gla(0), 32'h0000_0001);
    chk("R8 flag cleared", {16'b0, irq_flags}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R8 irq dropped", {31'b0, irq}, 32'h0);
    send(29'h10, 4'd0, 64'h0, 16'h0);
    chk("R8 lag flag", {16'b0, irq_flags}, 32'h1);
    chk("R8 lag irq low", {31'b0, irq}, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R8 lag irq high", {31'b0, irq}, 32'h1);
  endtask

  task automatic t_drop_commit();
    logic [31:0] v;
    apply_reset();
    setup_mb(4, 29'h3C, 29'h1FFFFFFF, 4'b0100);
    setup_mb(6, 29'h3C, 29'h1FFFFFFF, 4'b0100);
    rx_valid = 1'b1; rx_id = 29'h3C; rx_len = 4'd1; rx_data = 64'h9; timer = 16'h0005;
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0;
    reg_we = 1'b1; reg_addr = mba(4, 0); reg_wdata = 32'h0;
    @(posedge clk); @(negedge clk);
    reg_we = 1'b0;
    chk("R9 commit-cycle fallthrough", {16'b0, irq_flags}, 32'h0000_0040);
    rd(mba(4, 0), v); chk("R9 mb4 inactive", v & 32'hF, 32'h0);
    rd(mba(6, 0), v); chk("R9 mb6 full", v, 32'h0005_0102);
  endtask

  task automatic t_drop_sample();
    logic [31:0] v;
    apply_reset();
    setup_mb(4, 29'h3C, 29'h1FFFFFFF, 4'b0100);
    setup_mb(6, 29'h3C, 29'h1FFFFFFF, 4'b0100);
    rx_valid = 1'b1; rx_id = 29'h3C; rx_len = 4'd2; rx_data = 64'h9; timer = 16'h0006;
    reg_we = 1'b1; reg_addr = mba(4, 0); reg_wdata = 32'h0;
    @(posedge clk); @(negedge clk);
    rx_valid = 1'b0; reg_we = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R9 sample-cycle fallthrough", {16'b0, irq_flags}, 32'h0000_0040);
    rd(mba(6, 0), v); chk("R9 mb6 stored", v, 32'h0006_0202);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_lowest();
    t_overrun();
    t_mask();
    t_irq();
    t_drop_commit();
    t_drop_sample();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule